// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits beside a small word-addressed memory and carries out indivisible read-modify-write operations for several requesters that share one port. Each accepted request reads the addressed storage in its first cycle and writes back in its second. The reply carries the word as it was before the operation, or for conditional operations a pass/fail flag together with that old word. Plain loads and stores use the same two-cycle path, so every access to the memory goes through a single point.

For load-link/store-conditional sequences the unit keeps one link reservation per requester. A reservation is lost when anything writes to its line, or when an external invalidate or evict notice names that line. This holds even if the stored value has returned to what the load-link saw, so an A-to-B-to-A change is caught. A double-width compare-and-swap on an even/odd word pair gives software the same protection through a pointer paired with a sequence count. Lines are a power-of-two group of words, set by a parameter, and serve only for matching reservations.

Top module: `amo_unit`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle `req_ready` and `rsp_valid` are low. One edge later `rsp_valid` is high for one cycle with the result, and `req_ready` is high again.
- R2: Load (opcode 0) returns the addressed word with `rsp_ok`=1 and writes nothing. Store (opcode 1) writes the low word of `req_wdata` and echoes it in `rsp_data` with `rsp_ok`=1.
- R3: Test-and-set (opcode 2) returns the old word and leaves the value 1 in it.
- R4: Swap (opcode 3) returns the old word and stores the low word of `req_wdata`.
- R5: Fetch-and-increment (opcode 4) stores old+1, and fetch-and-add (opcode 5) stores old plus the low word of `req_wdata`. Both return the old word, and both wrap modulo 2^DATA_W.
- R6: Compare-and-swap (opcode 6) returns the old word. It sets `rsp_ok` only when the old word equals the low word of `req_cmp`, and only then stores the low word of `req_wdata`.
- R7: Pair compare-and-swap (opcode 7) compares {word addr+1, word addr} with all of `req_cmp`. On equality it writes all of `req_wdata` (high half to addr+1) and sets `rsp_ok`. An odd address always fails and writes nothing. `rsp_data` holds the old word at the given address.
- R8: Load-link (opcode 8) returns the word and records its address as the issuer's reservation, replacing any earlier one.
- R9: Store-conditional (opcode 9) writes the low word of `req_wdata` and sets `rsp_ok` only if the issuer holds a reservation for exactly that address. Otherwise memory is unchanged. It returns the old word, and either outcome drops the issuer's reservation.
- R10: Any write to a line, from a store or a successful atomic by any requester, drops every reservation on that line. This applies even when the value written equals the original. A line is 2^LINE_LOG2 words (addr >> LINE_LOG2).
- R11: `inv_valid` or `evict_valid` drops every reservation whose line matches the given address. When such a notice comes in the same cycle as a request, the notice acts first.
- R12: An opcode outside 0..9 returns the old word with `rsp_ok`=0 and writes nothing.
- R13: Reset clears all reservations, `rsp_valid` and `busy`. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 4 | Operation code |
| req_id | input | ID_W | Requester number |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*DATA_W | Store/new value (low word, or pair) |
| req_cmp | input | 2*DATA_W | Compare value (low word, or pair) |
| inv_valid | input | 1 | External invalidate notice |
| inv_addr | input | ADDR_W | Word address of invalidated line |
| evict_valid | input | 1 | External evict notice |
| evict_addr | input | ADDR_W | Word address of evicted line |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | DATA_W | Old word (or stored word for a store) |
| rsp_ok | output | 1 | Success flag |

## Verification
The bench aims at the A-to-B-to-A sequence. In that sequence another requester rewrites the original value, and a unit that compared values instead of tracking writes would let the store-conditional succeed. It also writes a neighbouring word in the same line, where per-word matching would fail to kill the reservation, and stores to a different line, where over-eager matching would kill it wrongly. It aims a pair compare-and-swap at an odd address whose contents do match, so a missing alignment guard would show as a write. An invalidate is raised in the very cycle a store-conditional is presented; a unit that ordered them the other way would report success. Increment wrap at all-ones, a replaced load-link address, and reservations surviving reset are also checked at the ports.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_LOAD      = 4'd0,
    OP_STORE     = 4'd1,
    OP_TAS       = 4'd2,
    OP_SWAP      = 4'd3,
    OP_FINC      = 4'd4,
    OP_FADD      = 4'd5,
    OP_CAS       = 4'd6,
    OP_CAS_PAIR  = 4'd7,
    OP_LINK      = 4'd8,
    OP_COND      = 4'd9
  } amo_op_e;

endpackage

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [1:0]          we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*DATA_W-1:0] wd,
  output wire  [2*DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << IDX_W;

  // Two independent word-wide banks so each half can be written alone.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DATA_W-1:0] ram [DEPTH];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[h]) ram[wr_idx] <= wd[h*DATA_W +: DATA_W];
      if (rd_en) q <= ram[rd_idx];
    end

    assign rd[h*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]          op,
  input  logic                half,
  input  logic [2*DATA_W-1:0] old_pair,
  input  logic [2*DATA_W-1:0] wdata,
  input  logic [2*DATA_W-1:0] cmp,
  input  logic                resv_hold,
  output logic [1:0]          we,
  output logic [2*DATA_W-1:0] new_pair,
  output logic [DATA_W-1:0]   rsp_word,
  output logic                ok
);
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] new_word;
  logic [DATA_W-1:0] wd_lo;
  logic [DATA_W-1:0] cmp_lo;
  logic              we_one;
  logic              pair_mode;
  logic              pair_eq;

  assign wd_lo  = wdata[DATA_W-1:0];
  assign cmp_lo = cmp[DATA_W-1:0];

  always_comb begin
    old_word  = half ? old_pair[2*DATA_W-1:DATA_W] : old_pair[DATA_W-1:0];
    new_word  = old_word;
    rsp_word  = old_word;
    we_one    = 1'b0;
    ok        = 1'b1;
    pair_mode = 1'b0;
    pair_eq   = 1'b0;
    case (op)
      OP_LOAD: ;
      OP_STORE: begin
        new_word = wd_lo;
        we_one   = 1'b1;
        rsp_word = wd_lo;
      end
      OP_TAS: begin
        new_word = DATA_W'(1);
        we_one   = 1'b1;
      end
      OP_SWAP: begin
        new_word = wd_lo;
        we_one   = 1'b1;
      end
      OP_FINC: begin
        new_word = old_word + DATA_W'(1);
        we_one   = 1'b1;
      end
      OP_FADD: begin
        new_word = old_word + wd_lo;
        we_one   = 1'b1;
      end
      OP_CAS: begin
        new_word = wd_lo;
        we_one   = (old_word == cmp_lo);
        ok       = (old_word == cmp_lo);
      end
      OP_CAS_PAIR: begin
        pair_mode = 1'b1;
        pair_eq   = !half && (old_pair == cmp);
        ok        = pair_eq;
      end
      OP_LINK: ;
      OP_COND: begin
        new_word = wd_lo;
        we_one   = resv_hold;
        ok       = resv_hold;
      end
      default: ok = 1'b0;
    endcase

    new_pair = pair_mode ? wdata : {new_word, new_word};
    if (pair_mode)
      we = pair_eq ? 2'b11 : 2'b00;
    else if (we_one)
      we = half ? 2'b10 : 2'b01;
    else
      we = 2'b00;
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int ADDR_W    = 6,
  parameter int ID_W      = 2,
  parameter int LINE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              ex_valid,
  input  logic [ID_W-1:0]   ex_id,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              ex_link,
  input  logic              ex_cond,
  input  logic              ex_wrote,
  output logic              hold
);
  localparam int NUM_REQ = 1 << ID_W;
  localparam int LINE_AW = ADDR_W - LINE_LOG2;

  logic [NUM_REQ-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q   [NUM_REQ];
  logic [LINE_AW-1:0] res_line [NUM_REQ];
  logic [NUM_REQ-1:0] kill_ext;
  logic [NUM_REQ-1:0] kill;
  logic [NUM_REQ-1:0] set;

  logic [LINE_AW-1:0] inv_line;
  logic [LINE_AW-1:0] ev_line;
  logic [LINE_AW-1:0] ex_line;

  assign inv_line = inv_addr[ADDR_W-1:LINE_LOG2];
  assign ev_line  = evict_addr[ADDR_W-1:LINE_LOG2];
  assign ex_line  = ex_addr[ADDR_W-1:LINE_LOG2];

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_slot
    assign res_line[r] = addr_q[r][ADDR_W-1:LINE_LOG2];
    assign kill_ext[r] = (inv_valid && inv_line == res_line[r]) ||
                         (evict_valid && ev_line == res_line[r]);
    assign set[r]      = ex_valid && ex_link && (ex_id == ID_W'(r));
    assign kill[r]     = kill_ext[r] ||
                         (ex_valid && ex_wrote && ex_line == res_line[r]) ||
                         (ex_valid && ex_cond && (ex_id == ID_W'(r)));

    // R11
    inv_kill_chk: assert property (@(posedge clk) disable iff (rst)
      (inv_valid && valid_q[r] && inv_line == res_line[r] && !set[r]) |=> !valid_q[r]);

    // R11
    evict_kill_chk: assert property (@(posedge clk) disable iff (rst)
      (evict_valid && valid_q[r] && ev_line == res_line[r] && !set[r]) |=> !valid_q[r]);

    // R10
    write_kill_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_valid && ex_wrote && valid_q[r] && ex_line == res_line[r] && !set[r])
        |=> !valid_q[r]);

    // R9
    cond_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_valid && ex_cond && ex_id == ID_W'(r)) |=> !valid_q[r]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (set[r]) begin
          valid_q[r] <= 1'b1;
          addr_q[r]  <= ex_addr;
        end else if (kill[r]) begin
          valid_q[r] <= 1'b0;
        end
      end
    end
  end

  // Notices arriving in the execute cycle act before the conditional store.
  assign hold = valid_q[ex_id] && (addr_q[ex_id] == ex_addr) && !kill_ext[ex_id];

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int ID_W      = 2,
  parameter int LINE_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_op,
  input  logic [ID_W-1:0]     req_id,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*DATA_W-1:0] req_wdata,
  input  logic [2*DATA_W-1:0] req_cmp,
  input  logic                inv_valid,
  input  logic [ADDR_W-1:0]   inv_addr,
  input  logic                evict_valid,
  input  logic [ADDR_W-1:0]   evict_addr,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_ok
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int PAIR_W = 2 * DATA_W;

  logic              busy_q;
  logic              accept;
  logic [3:0]        ex_op;
  logic [ID_W-1:0]   ex_id;
  logic [ADDR_W-1:0] ex_addr;
  logic [PAIR_W-1:0] ex_wdata;
  logic [PAIR_W-1:0] ex_cmp;

  logic [PAIR_W-1:0] rd_pair;
  logic [1:0]        alu_we;
  logic [1:0]        mem_we;
  logic [PAIR_W-1:0] alu_pair;
  logic [DATA_W-1:0] alu_word;
  logic              alu_ok;
  logic              resv_hold;

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign mem_we    = busy_q ? alu_we : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      busy_q    <= accept;
      rsp_valid <= busy_q;
      if (busy_q) begin
        rsp_data <= alu_word;
        rsp_ok   <= alu_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ex_op    <= req_op;
      ex_id    <= req_id;
      ex_addr  <= req_addr;
      ex_wdata <= req_wdata;
      ex_cmp   <= req_cmp;
    end
  end

  amo_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mem_i (
    .clk    (clk),
    .rd_en  (accept),
    .rd_idx (req_addr[ADDR_W-1:1]),
    .we     (mem_we),
    .wr_idx (ex_addr[ADDR_W-1:1]),
    .wd     (alu_pair),
    .rd     (rd_pair)
  );

  amo_alu #(.DATA_W(DATA_W)) alu_i (
    .op        (ex_op),
    .half      (ex_addr[0]),
    .old_pair  (rd_pair),
    .wdata     (ex_wdata),
    .cmp       (ex_cmp),
    .resv_hold (resv_hold),
    .we        (alu_we),
    .new_pair  (alu_pair),
    .rsp_word  (alu_word),
    .ok        (alu_ok)
  );

  amo_resv #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LINE_LOG2(LINE_LOG2)) resv_i (
    .clk         (clk),
    .rst         (rst),
    .inv_valid   (inv_valid),
    .inv_addr    (inv_addr),
    .evict_valid (evict_valid),
    .evict_addr  (evict_addr),
    .ex_valid    (busy_q),
    .ex_id       (ex_id),
    .ex_addr     (ex_addr),
    .ex_link     (ex_op == OP_LINK),
    .ex_cond     (ex_op == OP_COND),
    .ex_wrote    (|mem_we),
    .hold        (resv_hold)
  );

  // R1
  accept_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!req_ready && !rsp_valid) ##1 rsp_valid);

  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(busy_q));

  // R7
  pair_we_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ex_op == OP_CAS_PAIR) |-> (mem_we == 2'b00 || mem_we == 2'b11));

  // R9
  cond_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ex_op == OP_COND && !resv_hold) |-> (mem_we == 2'b00));

  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ex_op > 4'd9) |-> (mem_we == 2'b00));

endmodule

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  id;
    logic [5:0]  a;
    logic [63:0] wd;
    logic [63:0] cm;
    logic [31:0] ed;
    logic        eo;
  } vec_t;

  localparam int NV = 57;
  // Opcodes: 0 load, 1 store, 2 tas, 3 swap, 4 inc, 5 add, 6 cas, 7 pair cas, 8 link, 9 cond
  localparam vec_t VEC [NV] = '{
    '{4'd1, 2'd0, 6'd0,  64'd5,            64'd0,  32'd5,          1'b1}, // 0  R2
    '{4'd0, 2'd0, 6'd0,  64'd0,            64'd0,  32'd5,          1'b1},
    '{4'd2, 2'd0, 6'd0,  64'd0,            64'd0,  32'd5,          1'b1}, // R3
    '{4'd0, 2'd0, 6'd0,  64'd0,            64'd0,  32'd1,          1'b1},
    '{4'd1, 2'd0, 6'd1,  64'd0,            64'd0,  32'd0,          1'b1},
    '{4'd2, 2'd0, 6'd1,  64'd0,            64'd0,  32'd0,          1'b1}, // 5
    '{4'd0, 2'd0, 6'd1,  64'd0,            64'd0,  32'd1,          1'b1},
    '{4'd3, 2'd0, 6'd1,  64'hAB,           64'd0,  32'd1,          1'b1}, // R4
    '{4'd0, 2'd0, 6'd1,  64'd0,            64'd0,  32'hAB,         1'b1},
    '{4'd4, 2'd0, 6'd1,  64'd0,            64'd0,  32'hAB,         1'b1}, // R5
    '{4'd0, 2'd0, 6'd1,  64'd0,            64'd0,  32'hAC,         1'b1}, // 10
    '{4'd1, 2'd0, 6'd2,  64'hFFFFFFFF,     64'd0,  32'hFFFFFFFF,   1'b1},
    '{4'd4, 2'd0, 6'd2,  64'd0,            64'd0,  32'hFFFFFFFF,   1'b1},
    '{4'd0, 2'd0, 6'd2,  64'd0,            64'd0,  32'd0,          1'b1},
    '{4'd5, 2'd0, 6'd2,  64'd10,           64'd0,  32'd0,          1'b1},
    '{4'd0, 2'd0, 6'd2,  64'd0,            64'd0,  32'd10,         1'b1}, // 15
    '{4'd6, 2'd0, 6'd2,  64'd77,           64'd9,  32'd10,         1'b0}, // R6
    '{4'd0, 2'd0, 6'd2,  64'd0,            64'd0,  32'd10,         1'b1},
    '{4'd6, 2'd0, 6'd2,  64'd77,           64'd10, 32'd10,         1'b1},
    '{4'd0, 2'd0, 6'd2,  64'd0,            64'd0,  32'd77,         1'b1},
    '{4'd1, 2'd0, 6'd4,  64'h11,           64'd0,  32'h11,         1'b1}, // 20
    '{4'd1, 2'd0, 6'd5,  64'h22,           64'd0,  32'h22,         1'b1},
    '{4'd7, 2'd0, 6'd4,  64'h00000044_00000033, 64'h00000022_00000011, 32'h11, 1'b1}, // R7
    '{4'd0, 2'd0, 6'd4,  64'd0,            64'd0,  32'h33,         1'b1},
    '{4'd0, 2'd0, 6'd5,  64'd0,            64'd0,  32'h44,         1'b1},
    '{4'd7, 2'd0, 6'd4,  64'd0,            64'h00000044_00000000, 32'h33, 1'b0}, // 25
    '{4'd0, 2'd0, 6'd4,  64'd0,            64'd0,  32'h33,         1'b1},
    '{4'd7, 2'd0, 6'd5,  64'd0,            64'h00000044_00000033, 32'h44, 1'b0},
    '{4'd1, 2'd0, 6'd8,  64'd7,            64'd0,  32'd7,          1'b1},
    '{4'd8, 2'd1, 6'd8,  64'd0,            64'd0,  32'd7,          1'b1}, // R8
    '{4'd9, 2'd1, 6'd8,  64'd9,            64'd0,  32'd7,          1'b1}, // 30 R9
    '{4'd0, 2'd0, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1},
    '{4'd9, 2'd1, 6'd8,  64'd3,            64'd0,  32'd9,          1'b0},
    '{4'd0, 2'd0, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1},
    '{4'd8, 2'd1, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1}, // R10 value restored
    '{4'd1, 2'd2, 6'd8,  64'd1,            64'd0,  32'd1,          1'b1}, // 35
    '{4'd1, 2'd2, 6'd8,  64'd9,            64'd0,  32'd9,          1'b1},
    '{4'd9, 2'd1, 6'd8,  64'd5,            64'd0,  32'd9,          1'b0},
    '{4'd0, 2'd0, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1},
    '{4'd8, 2'd1, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1}, // same line
    '{4'd1, 2'd2, 6'd9,  64'd4,            64'd0,  32'd4,          1'b1}, // 40
    '{4'd9, 2'd1, 6'd8,  64'd5,            64'd0,  32'd9,          1'b0},
    '{4'd8, 2'd1, 6'd8,  64'd0,            64'd0,  32'd9,          1'b1}, // other line
    '{4'd1, 2'd2, 6'd12, 64'd6,            64'd0,  32'd6,          1'b1},
    '{4'd9, 2'd1, 6'd8,  64'd2,            64'd0,  32'd9,          1'b1},
    '{4'd0, 2'd0, 6'd8,  64'd0,            64'd0,  32'd2,          1'b1}, // 45
    '{4'd8, 2'd3, 6'd8,  64'd0,            64'd0,  32'd2,          1'b1}, // R8 replace
    '{4'd8, 2'd3, 6'd9,  64'd0,            64'd0,  32'd4,          1'b1},
    '{4'd9, 2'd3, 6'd8,  64'd1,            64'd0,  32'd2,          1'b0},
    '{4'd8, 2'd3, 6'd9,  64'd0,            64'd0,  32'd4,          1'b1},
    '{4'd9, 2'd3, 6'd9,  64'd8,            64'd0,  32'd4,          1'b1}, // 50
    '{4'd15,2'd0, 6'd8,  64'd99,           64'd0,  32'd2,          1'b0}, // R12
    '{4'd0, 2'd0, 6'd8,  64'd0,            64'd0,  32'd2,          1'b1},
    '{4'd8, 2'd0, 6'd12, 64'd0,            64'd0,  32'd6,          1'b1}, // R10 cross requester
    '{4'd8, 2'd1, 6'd12, 64'd0,            64'd0,  32'd6,          1'b1},
    '{4'd9, 2'd1, 6'd12, 64'd3,            64'd0,  32'd6,          1'b1}, // 55
    '{4'd9, 2'd0, 6'd12, 64'd4,            64'd0,  32'd3,          1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_id = '0;
  logic [5:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_cmp = '0;
  logic        inv_valid = 1'b0;
  logic [5:0]  inv_addr = '0;
  logic        evict_valid = 1'b0;
  logic [5:0]  evict_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_ok;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_id(req_id), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  task automatic check(input logic cond, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [1:0] id, input logic [5:0] a,
                       input logic [63:0] wd, input logic [63:0] cm,
                       input logic [31:0] ed, input logic eo,
                       input logic inv_now, input logic [5:0] inv_a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_id = id; req_addr = a;
    req_wdata = wd; req_cmp = cm;
    inv_valid = inv_now; inv_addr = inv_a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; inv_valid = 1'b0;
    // R1: busy cycle
    check(!req_ready && !rsp_valid, "R1", {62'd0, req_ready, rsp_valid}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid && req_ready && rsp_data == ed && rsp_ok == eo, tag,
          {30'd0, rsp_valid, rsp_ok, rsp_data}, {30'd0, 1'b1, eo, ed});
  endtask

  task automatic pulse_evict(input logic [5:0] a);
    @(negedge clk);
    evict_valid = 1'b1; evict_addr = a;
    @(negedge clk);
    evict_valid = 1'b0;
  endtask

  task automatic pulse_inv(input logic [5:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic string tag_of(input int i, input logic [3:0] op);
    if ((i >= 34 && i <= 44) || i >= 53) return "R10";
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R12";
    endcase
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: idle state after reset
    check(req_ready && !rsp_valid, "R13", {62'd0, req_ready, rsp_valid}, 64'd2);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i].op, VEC[i].id, VEC[i].a, VEC[i].wd, VEC[i].cm,
            VEC[i].ed, VEC[i].eo, 1'b0, 6'd0, tag_of(i, VEC[i].op));

    // R11: evict of a neighbouring word in the line
    do_op(4'd1, 2'd0, 6'd16, 64'h50, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R2");
    do_op(4'd8, 2'd0, 6'd16, 64'd0, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R8");
    pulse_evict(6'd17);
    do_op(4'd9, 2'd0, 6'd16, 64'd1, 64'd0, 32'h50, 1'b0, 1'b0, 6'd0, "R11");

    // R11: invalidate in an idle cycle
    do_op(4'd8, 2'd0, 6'd16, 64'd0, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R8");
    pulse_inv(6'd19);
    do_op(4'd9, 2'd0, 6'd16, 64'd1, 64'd0, 32'h50, 1'b0, 1'b0, 6'd0, "R11");

    // R11: invalidate in the same cycle as the conditional store acts first
    do_op(4'd8, 2'd0, 6'd16, 64'd0, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R8");
    do_op(4'd9, 2'd0, 6'd16, 64'd1, 64'd0, 32'h50, 1'b0, 1'b1, 6'd18, "R11");
    do_op(4'd0, 2'd0, 6'd16, 64'd0, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R11");

    // R11: invalidate of a different line leaves the reservation intact
    do_op(4'd8, 2'd0, 6'd16, 64'd0, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R8");
    pulse_inv(6'd20);
    do_op(4'd9, 2'd0, 6'd16, 64'h51, 64'd0, 32'h50, 1'b1, 1'b0, 6'd0, "R11");
    do_op(4'd0, 2'd0, 6'd16, 64'd0, 64'd0, 32'h51, 1'b1, 1'b0, 6'd0, "R9");

    // R13: reset drops reservations, memory keeps its contents
    do_op(4'd8, 2'd2, 6'd16, 64'd0, 64'd0, 32'h51, 1'b1, 1'b0, 6'd0, "R8");
    apply_reset();
    @(negedge clk);
    check(req_ready && !rsp_valid, "R13", {62'd0, req_ready, rsp_valid}, 64'd2);
    do_op(4'd9, 2'd2, 6'd16, 64'd7, 64'd0, 32'h51, 1'b0, 1'b0, 6'd0, "R13");
    do_op(4'd0, 2'd0, 6'd16, 64'd0, 64'd0, 32'h51, 1'b1, 1'b0, 6'd0, "R13");

    finish_run();
  end

endmodule